// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This block is a 16-bit timer/counter for a controller whose machine cycle lasts twelve oscillator clocks. It either counts machine cycles (timer function) or counts falling edges on an external count pin (counter function). Both external pins pass through a synchronizer and are sampled once per machine cycle. A falling edge is recognised only when one sample is high and the next sample is low.

In capture mode a falling edge on the second external pin copies the running count into the capture/reload register pair and raises the external flag. In auto-reload mode the count is reloaded from that same register pair. A reload happens when the count wraps past 0xFFFF, or on a falling edge of the second pin. When down-counting is enabled, the level of the second pin chooses the count direction instead. Both flags are sticky. Their OR drives the interrupt request.

Software reaches the registers through a byte-wide write port and a registered read port.

Top module: `cr_timer16`

## Requirements
- R1: After reset, every register reads back 0x00 and irq is 0.
- R2: Register map by addr: 0 control, 1 mode (bit0 = down-count enable, other bits read 0), 2/3 count low/high byte, 4/5 capture/reload low/high byte. Control bits: 0 run, 1 counter function, 2 capture select, 3 external enable, 4 and 5 serial-clock selects, 6 external flag, 7 overflow flag. rd_data shows the register addressed on the previous clock. A software write to a register wins over a hardware update in the same clock.
- R3: In timer function the count advances exactly once every 12 clocks while it runs, so 120 running clocks add exactly 10.
- R4: In counter function the count pin is sampled once per machine cycle, and the count rises by one for each high sample followed by a low sample.
- R5: When run is 0, or either serial-clock select is 1, the count and both flags do not change unless software writes them.
- R6: In capture mode the count wraps from 0xFFFF to 0x0000 and sets the overflow flag.
- R7: In capture mode with external enable set, a falling edge on ext_pin copies the count into the capture pair and sets the external flag. With external enable clear, such an edge changes nothing.
- R8: In auto-reload mode with down-count disabled, the step after 0xFFFF loads the reload pair and sets the overflow flag.
- R9: In that up-counting reload mode with external enable set, a falling edge on ext_pin loads the reload pair and sets the external flag.
- R10: With down-count enabled in auto-reload mode, a sampled ext_pin high counts up and low counts down. Down-counting from a count equal to the reload value loads 0xFFFF. Either wrap sets the overflow flag and toggles the external flag. Edges on ext_pin cause no reload.
- R11: Both flags stay set until software writes them. irq equals the OR of the two flags in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data |
| cnt_pin | input | 1 | External count input |
| ext_pin | input | 1 | Capture/reload trigger or count-direction input |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a wrap in down-count mode. It needs the direction pin to be sampled before the run starts, a reload value just below the count, and an exact number of machine cycles. The external-flag toggle then has to be seen before software overwrites it. The stimulus loads the count and reload registers while stopped, lets the synchronized direction settle, and runs for a whole number of 12-clock periods. Because the prescaler is free-running, that gives a deterministic number of steps. The control register is read back in the machine cycle right after the wrap. A behavioural model checks rd_data and irq on every clock across all of these runs.

// File: rtl/cr_timer16_pkg.sv
package cr_timer16_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_MODE   = 3'd1;
  localparam logic [REG_AW-1:0] A_CNT_LO = 3'd2;
  localparam logic [REG_AW-1:0] A_CNT_HI = 3'd3;
  localparam logic [REG_AW-1:0] A_RLD_LO = 3'd4;
  localparam logic [REG_AW-1:0] A_RLD_HI = 3'd5;

  localparam int B_RUN  = 0;
  localparam int B_CTR  = 1;
  localparam int B_CAP  = 2;
  localparam int B_EXEN = 3;
  localparam int B_SCK0 = 4;
  localparam int B_SCK1 = 5;
  localparam int CFG_W  = 6;

  typedef struct packed {
    logic ovf;
    logic ext;
    logic sck1;
    logic sck0;
    logic ext_en;
    logic cap_sel;
    logic ctr_sel;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/cr_tmr_mcycle.sv
module cr_tmr_mcycle #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic tick_late
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      tick_late <= 1'b0;
    end else begin
      tick_late <= tick;
      if (div_q == LAST) div_q <= '0;
      else               div_q <= div_q + CW'(1);
    end
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/cr_tmr_pinsamp.sv
module cr_tmr_pinsamp #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic level,
  output logic prev
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      level  <= 1'b0;
      prev   <= 1'b0;
    end else begin
      sync_q[0] <= pin;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      if (tick) begin
        prev  <= level;
        level <= sync_q[SYNC_STAGES-1];
      end
    end
  end
endmodule

// File: rtl/cr_tmr_core.sv
module cr_tmr_core #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic                cap_mode,
  input  logic                ext_en,
  input  logic                down_en,
  input  logic                step,
  input  logic                ext_fall,
  input  logic                ext_level,
  input  logic                wr_cnt_lo,
  input  logic                wr_cnt_hi,
  input  logic                wr_rld_lo,
  input  logic                wr_rld_hi,
  input  logic                wr_flags,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [2*DATA_W-1:0] cnt,
  output logic [2*DATA_W-1:0] rld,
  output logic                ovf,
  output logic                ext,
  output logic                irq
);
  localparam int CW = 2 * DATA_W;
  localparam logic [CW-1:0] ALL1 = '1;

  logic [CW-1:0] cnt_n, rld_n;
  logic          ovf_n, ext_n, ext_hit;

  assign ext_hit = ext_en & ext_fall;

  always_comb begin
    cnt_n = cnt;
    rld_n = rld;
    ovf_n = ovf;
    ext_n = ext;
    if (active) begin
      if (cap_mode) begin
        if (step) begin
          cnt_n = cnt + CW'(1);
          if (cnt == ALL1) ovf_n = 1'b1;
        end
        if (ext_hit) begin
          rld_n = cnt;
          ext_n = 1'b1;
        end
      end else if (!down_en) begin
        if (step) begin
          if (cnt == ALL1) begin
            cnt_n = rld;
            ovf_n = 1'b1;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        if (ext_hit) begin
          cnt_n = rld;
          ext_n = 1'b1;
        end
      end else if (step) begin
        if (ext_level) begin
          if (cnt == ALL1) begin
            cnt_n = rld;
            ovf_n = 1'b1;
            ext_n = ~ext;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end else begin
          if (cnt == rld) begin
            cnt_n = ALL1;
            ovf_n = 1'b1;
            ext_n = ~ext;
          end else begin
            cnt_n = cnt - CW'(1);
          end
        end
      end
    end
    if (wr_cnt_lo) cnt_n[DATA_W-1:0]  = wr_data;
    if (wr_cnt_hi) cnt_n[CW-1:DATA_W] = wr_data;
    if (wr_rld_lo) rld_n[DATA_W-1:0]  = wr_data;
    if (wr_rld_hi) rld_n[CW-1:DATA_W] = wr_data;
    if (wr_flags) begin
      ovf_n = wr_data[7];
      ext_n = wr_data[6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rld <= '0;
      ovf <= 1'b0;
      ext <= 1'b0;
      irq <= 1'b0;
    end else begin
      cnt <= cnt_n;
      rld <= rld_n;
      ovf <= ovf_n;
      ext <= ext_n;
      irq <= ovf_n | ext_n;
    end
  end
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import cr_timer16_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_PER_MC  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cnt_pin,
  input  logic              ext_pin,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int NPIN  = 2;

  logic [CFG_W-1:0] cfg_q;
  logic             down_q;
  logic             mc_tick, tick_late;
  logic [NPIN-1:0]  pins, lvl, prv, fall_w;
  logic             step_w, active_w;
  logic [CNT_W-1:0] cnt_w, rld_w;
  logic             ovf_w, ext_w;
  logic             wr_ctrl, wr_mode, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi;
  ctrl_t            ctrl_view;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_mode   = wr_en && (addr == A_MODE);
  assign wr_cnt_lo = wr_en && (addr == A_CNT_LO);
  assign wr_cnt_hi = wr_en && (addr == A_CNT_HI);
  assign wr_rld_lo = wr_en && (addr == A_RLD_LO);
  assign wr_rld_hi = wr_en && (addr == A_RLD_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (wr_ctrl) cfg_q  <= wr_data[CFG_W-1:0];
      if (wr_mode) down_q <= wr_data[0];
    end
  end

  cr_tmr_mcycle #(.DIV(CLK_PER_MC)) u_mcycle (
    .clk       (clk),
    .rst       (rst),
    .tick      (mc_tick),
    .tick_late (tick_late)
  );

  assign pins = {ext_pin, cnt_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    cr_tmr_pinsamp #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk   (clk),
      .rst   (rst),
      .tick  (mc_tick),
      .pin   (pins[g]),
      .level (lvl[g]),
      .prev  (prv[g])
    );
    assign fall_w[g] = tick_late & prv[g] & ~lvl[g];
  end

  assign active_w = cfg_q[B_RUN] & ~cfg_q[B_SCK0] & ~cfg_q[B_SCK1];
  assign step_w   = cfg_q[B_CTR] ? fall_w[0] : mc_tick;

  cr_tmr_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .active    (active_w),
    .cap_mode  (cfg_q[B_CAP]),
    .ext_en    (cfg_q[B_EXEN]),
    .down_en   (down_q),
    .step      (step_w),
    .ext_fall  (fall_w[1]),
    .ext_level (lvl[1]),
    .wr_cnt_lo (wr_cnt_lo),
    .wr_cnt_hi (wr_cnt_hi),
    .wr_rld_lo (wr_rld_lo),
    .wr_rld_hi (wr_rld_hi),
    .wr_flags  (wr_ctrl),
    .wr_data   (wr_data),
    .cnt       (cnt_w),
    .rld       (rld_w),
    .ovf       (ovf_w),
    .ext       (ext_w),
    .irq       (irq)
  );

  assign ctrl_view = {ovf_w, ext_w, cfg_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (addr)
        A_CTRL:   rd_data <= DATA_W'(ctrl_view);
        A_MODE:   rd_data <= DATA_W'(down_q);
        A_CNT_LO: rd_data <= cnt_w[DATA_W-1:0];
        A_CNT_HI: rd_data <= cnt_w[CNT_W-1:DATA_W];
        A_RLD_LO: rd_data <= rld_w[DATA_W-1:0];
        A_RLD_HI: rd_data <= rld_w[CNT_W-1:DATA_W];
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cr_timer16_chk.sv
module cr_timer16_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        cnt_fall,
  input logic        ext_fall,
  input logic        step,
  input logic        active,
  input logic        cap_mode,
  input logic        ext_en,
  input logic        down_en,
  input logic [15:0] cnt,
  input logic [15:0] rld,
  input logic        ovf,
  input logic        ext,
  input logic        irq,
  input logic        wr_cnt,
  input logic        wr_rld,
  input logic        wr_ctrl
);
  // R3: machine-cycle strobes never sit on adjacent clocks
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R4: a count-pin edge pulse only follows a sampling strobe
  assert_count_after_sample_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_fall |-> $past(tick));

  // R5: a stopped timer holds its count
  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr_cnt) |=> $stable(cnt));

  // R7: capture copies the running count and raises the external flag
  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (active && cap_mode && ext_en && ext_fall && !wr_rld && !wr_ctrl)
      |=> (rld == $past(cnt)) && ext);

  // R8: up-count wrap in reload mode loads the reload pair
  assert_up_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (active && !cap_mode && !down_en && step && (cnt == 16'hFFFF)
      && !(ext_en && ext_fall) && !wr_cnt && !wr_ctrl)
      |=> (cnt == $past(rld)) && ovf);

  // R11: interrupt request tracks the flags
  assert_irq_or_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf | ext));
endmodule

bind cr_timer16 cr_timer16_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (mc_tick),
  .cnt_fall (fall_w[0]),
  .ext_fall (fall_w[1]),
  .step     (step_w),
  .active   (active_w),
  .cap_mode (cfg_q[2]),
  .ext_en   (cfg_q[3]),
  .down_en  (down_q),
  .cnt      (cnt_w),
  .rld      (rld_w),
  .ovf      (ovf_w),
  .ext      (ext_w),
  .irq      (irq),
  .wr_cnt   (wr_cnt_lo | wr_cnt_hi),
  .wr_rld   (wr_rld_lo | wr_rld_hi),
  .wr_ctrl  (wr_ctrl)
);

// File: tb/cr_timer16_tb_top.sv
`timescale 1ns/1ps
module cr_timer16_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       cnt_pin = 1'b0;
  logic       ext_pin = 1'b0;
  logic       irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    mdl_on  = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cr_timer16 dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_pin(cnt_pin), .ext_pin(ext_pin), .irq(irq)
  );

  // behavioural reference model
  int        m_pre;
  bit [1:0]  m_syc, m_sye;
  bit        m_clv, m_cfall, m_elv, m_efall;
  bit [5:0]  m_cfg;
  bit        m_down, m_ovf, m_ext, m_irq;
  bit [15:0] m_cnt, m_rld;
  bit [7:0]  m_rd;
  bit        t_tick, t_act, t_step, t_no, t_ne;
  bit [15:0] t_nc, t_nr;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_syc = 0; m_sye = 0; m_clv = 0; m_cfall = 0; m_elv = 0; m_efall = 0;
      m_cfg = 0; m_down = 0; m_ovf = 0; m_ext = 0; m_irq = 0; m_cnt = 0; m_rld = 0; m_rd = 0;
    end else begin
      t_tick = (m_pre == 11);
      t_act  = m_cfg[0] && !m_cfg[4] && !m_cfg[5];
      t_step = m_cfg[1] ? m_cfall : t_tick;
      t_nc = m_cnt; t_nr = m_rld; t_no = m_ovf; t_ne = m_ext;
      if (t_act) begin
        if (m_cfg[2]) begin
          if (t_step) begin
            if (m_cnt == 16'hFFFF) t_no = 1;
            t_nc = m_cnt + 16'd1;
          end
          if (m_cfg[3] && m_efall) begin t_nr = m_cnt; t_ne = 1; end
        end else if (!m_down) begin
          if (t_step) begin
            if (m_cnt == 16'hFFFF) begin t_nc = m_rld; t_no = 1; end
            else t_nc = m_cnt + 16'd1;
          end
          if (m_cfg[3] && m_efall) begin t_nc = m_rld; t_ne = 1; end
        end else if (t_step) begin
          if (m_elv) begin
            if (m_cnt == 16'hFFFF) begin t_nc = m_rld; t_no = 1; t_ne = !m_ext; end
            else t_nc = m_cnt + 16'd1;
          end else begin
            if (m_cnt == m_rld) begin t_nc = 16'hFFFF; t_no = 1; t_ne = !m_ext; end
            else t_nc = m_cnt - 16'd1;
          end
        end
      end
      case (addr)
        3'd0: m_rd = {m_ovf, m_ext, m_cfg};
        3'd1: m_rd = {7'd0, m_down};
        3'd2: m_rd = m_cnt[7:0];
        3'd3: m_rd = m_cnt[15:8];
        3'd4: m_rd = m_rld[7:0];
        3'd5: m_rd = m_rld[15:8];
        default: m_rd = 8'd0;
      endcase
      if (wr_en) begin
        case (addr)
          3'd0: begin m_cfg = wr_data[5:0]; t_no = wr_data[7]; t_ne = wr_data[6]; end
          3'd1: m_down = wr_data[0];
          3'd2: t_nc[7:0] = wr_data;
          3'd3: t_nc[15:8] = wr_data;
          3'd4: t_nr[7:0] = wr_data;
          3'd5: t_nr[15:8] = wr_data;
          default: ;
        endcase
      end
      m_cnt = t_nc; m_rld = t_nr; m_ovf = t_no; m_ext = t_ne;
      m_irq = t_no | t_ne;
      if (t_tick) begin
        m_cfall = m_clv & ~m_syc[1]; m_clv = m_syc[1];
        m_efall = m_elv & ~m_sye[1]; m_elv = m_sye[1];
      end else begin
        m_cfall = 0; m_efall = 0;
      end
      m_syc = {m_syc[0], cnt_pin};
      m_sye = {m_sye[0], ext_pin};
      m_pre = t_tick ? 0 : m_pre + 1;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (mdl_on && !rst) begin
      chk(cur_req, "model rd_data", int'(rd_data), int'(m_rd));
      chk(cur_req, "model irq", int'(irq), int'(m_irq));
    end
  end

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit [2:0] a, output bit [7:0] v);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd16(input bit [2:0] a, output bit [15:0] v);
    bit [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit [7:0]  v8;
    bit [15:0] v16, cap_keep;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    mdl_on = 1'b1;

    // R1: reset values
    cur_req = "R1";
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v8);
      chk("R1", "reset register", v8, 0);
    end
    chk("R1", "reset irq", irq, 0);

    // R2: register map and readback
    cur_req = "R2";
    wr(3'd1, 8'hFF); rd(3'd1, v8); chk("R2", "mode readback", v8, 8'h01);
    wr(3'd1, 8'hFE); rd(3'd1, v8); chk("R2", "mode bit0 clear", v8, 8'h00);
    wr(3'd4, 8'hEF); wr(3'd5, 8'hBE); rd16(3'd4, v16); chk("R2", "reload pair", v16, 16'hBEEF);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12); rd16(3'd2, v16); chk("R2", "count pair", v16, 16'h1234);

    // R3: timer function, 120 running clocks
    cur_req = "R3";
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h05); idle(119); wr(3'd0, 8'h04);
    rd16(3'd2, v16); chk("R3", "ticks in 120 clocks", v16, 10);

    // R4: counter function, five pin pulses
    cur_req = "R4";
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cnt_pin = 1'b0; idle(30);
    wr(3'd0, 8'h07);
    for (int k = 0; k < 5; k++) begin
      cnt_pin = 1'b1; idle(24);
      cnt_pin = 1'b0; idle(24);
    end
    idle(30); wr(3'd0, 8'h06);
    rd16(3'd2, v16); chk("R4", "pin falling edges counted", v16, 5);

    // R5: off states hold the count
    cur_req = "R5";
    wr(3'd2, 8'h50); wr(3'd3, 8'h00);
    wr(3'd0, 8'h11); idle(60);
    rd16(3'd2, v16); chk("R5", "count with serial select 0", v16, 16'h0050);
    wr(3'd0, 8'h21); idle(60);
    rd16(3'd2, v16); chk("R5", "count with serial select 1", v16, 16'h0050);
    rd(3'd0, v8); chk("R5", "flags unchanged", v8, 8'h21);
    wr(3'd0, 8'h04); idle(60);
    rd16(3'd2, v16); chk("R5", "count with run clear", v16, 16'h0050);

    // R6: capture-mode wrap sets overflow
    cur_req = "R6";
    wr(3'd2, 8'hFC); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h05); idle(71); wr(3'd0, 8'h84);
    rd16(3'd2, v16); chk("R6", "count after wrap", v16, 16'h0002);
    rd(3'd0, v8); chk("R6", "overflow flag set", v8, 8'h84);
    chk("R11", "irq with overflow", irq, 1);
    idle(30);
    rd(3'd0, v8); chk("R11", "flag sticky", v8, 8'h84);
    wr(3'd0, 8'h04);
    chk("R11", "irq after clear", irq, 0);

    // R7: capture on ext_pin edge
    cur_req = "R7";
    wr(3'd2, 8'h00); wr(3'd3, 8'h01);
    ext_pin = 1'b1; idle(30);
    wr(3'd0, 8'h0D); idle(50);
    ext_pin = 1'b0; idle(40);
    rd(3'd0, v8); chk("R7", "external flag after capture", v8, 8'h4D);
    wr(3'd0, 8'h4C);
    rd16(3'd4, cap_keep);
    chk("R7", "captured value in range", (cap_keep >= 16'h0101 && cap_keep <= 16'h0109), 1);
    wr(3'd0, 8'h05);
    ext_pin = 1'b1; idle(30); ext_pin = 1'b0; idle(30);
    rd(3'd0, v8); chk("R7", "no flag with enable clear", v8, 8'h05);
    wr(3'd0, 8'h04);
    rd16(3'd4, v16); chk("R7", "no capture with enable clear", v16, cap_keep);

    // R8: up-count reload
    cur_req = "R8";
    wr(3'd1, 8'h00);
    wr(3'd4, 8'hF0); wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h01); idle(35); wr(3'd0, 8'h80);
    rd16(3'd2, v16); chk("R8", "count after reload", v16, 16'hFFF1);
    rd(3'd0, v8); chk("R8", "overflow after reload", v8, 8'h80);

    // R9: ext_pin edge forces reload
    cur_req = "R9";
    wr(3'd4, 8'h11); wr(3'd5, 8'h11);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    ext_pin = 1'b1; idle(30);
    wr(3'd0, 8'h09); idle(20);
    ext_pin = 1'b0; idle(40);
    rd(3'd0, v8); chk("R9", "external flag on reload", v8, 8'h49);
    wr(3'd0, 8'h48);
    rd16(3'd2, v16); chk("R9", "count reloaded", (v16 >= 16'h1111 && v16 <= 16'h1116), 1);
    wr(3'd0, 8'h00);

    // R10: down counting
    cur_req = "R10";
    wr(3'd1, 8'h01);
    wr(3'd4, 8'h10); wr(3'd5, 8'h00);
    wr(3'd2, 8'h12); wr(3'd3, 8'h00);
    ext_pin = 1'b0; idle(30);
    wr(3'd0, 8'h01); idle(35); wr(3'd0, 8'hC0);
    rd16(3'd2, v16); chk("R10", "underflow loads all ones", v16, 16'hFFFF);
    rd(3'd0, v8); chk("R10", "flags after underflow", v8, 8'hC0);
    ext_pin = 1'b1; idle(30);
    wr(3'd0, 8'hC1); idle(12);
    rd(3'd0, v8); chk("R10", "external flag toggles on up wrap", v8, 8'h81);
    wr(3'd0, 8'h80);
    rd16(3'd2, v16); chk("R10", "up wrap loads reload", v16, 16'h0010);
    wr(3'd2, 8'h00); wr(3'd3, 8'h05);
    ext_pin = 1'b1; idle(30);
    wr(3'd0, 8'h09); idle(5);
    ext_pin = 1'b0; idle(40);
    wr(3'd0, 8'h08);
    rd(3'd0, v8); chk("R10", "edge sets no flag in down mode", v8, 8'h08);
    rd16(3'd2, v16); chk("R10", "edge causes no reload", (v16 >= 16'h04F0 && v16 <= 16'h0510), 1);

    idle(5);
    done = 1'b1;
    finish_run();
  end
endmodule